// File: doc/BRIEF.md
# Bounded-Regime Posit Encoder

This block turns an unpacked number into an n-bit posit word whose regime run is capped at six bits and whose exponent field is always five bits wide. The arithmetic datapath upstream hands over a sign, a signed binary scale, a fraction (with the hidden bit removed, MSB first) and a sticky flag. Two further flags mark a zero result or a Not-a-Real (NaR) result. The encoder returns the packed word one clock after the inputs are presented.

The regime can only take one of five lengths, from two to six bits. Packing therefore needs no barrel shifter. Each length has its own fixed layout of regime, exponent and fraction bits, and a five-way multiplexer keyed on the regime value picks one. The chosen magnitude is rounded to nearest with ties to even, clamped so that a nonzero value never becomes zero or NaR, and negated by two's complement when the sign is set. Scales outside the representable window saturate to the extreme magnitudes.

Top module: `bposit_encoder`

## Requirements
- R1: While `rst_n` is low, `word_o` reads all zeros.
- R2: When `nar_i` is high, the next `word_o` is a one in the top bit and zeros elsewhere, whatever the other inputs are. This includes `zero_i` being high at the same time.
- R3: When `zero_i` is high and `nar_i` is low, the next `word_o` is all zeros, whatever the other inputs are.
- R4: The regime value is `floor(scale/32)`. A value r ≥ 0 is written as r+1 ones and then a zero, except r = 5, which is six ones with no zero after them. A value r < 0 is written as −r zeros and then a one, except r = −6, which is six zeros with no one after them. The regime starts just below the sign bit.
- R5: The five bits right after the regime hold `scale mod 32`, MSB first. The remaining low bits hold the leading fraction bits.
- R6: Dropped fraction bits round to nearest, ties to even. The guard bit is the first dropped bit. The sticky bit is the OR of all later dropped bits together with `sticky_i`. A carry out of the fraction ripples into the exponent and regime.
- R7: For a nonzero input, a scale of 192 or more gives the largest magnitude (all ones below the sign bit). A scale below −192 gives the smallest magnitude (only bit 0 set).
- R8: For a nonzero input, a result that would round to an all-zero magnitude becomes the smallest magnitude. A result that would carry past the largest magnitude stays at the largest magnitude. So a nonzero input never yields zero or NaR.
- R9: With `sign_i` set and neither flag raised, `word_o` is the two's complement of the word the same input gives with `sign_i` clear.
- R10: `word_o` changes only at a rising clock edge, one cycle after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| scale_i | input | SCW | Signed binary scale (power of two) |
| frac_i | input | FW | Fraction after the hidden bit, MSB first |
| sticky_i | input | 1 | OR of any fraction bits beyond `frac_i` |
| zero_i | input | 1 | Value is exactly zero |
| nar_i | input | 1 | Value is NaR |
| word_o | output | NBITS | Encoded posit word |

## Verification
Rounding and saturation can both act in one cycle. A scale of 191 with an all-ones fraction and a set guard bit rounds upward into the sign position, and the clamp has to hold the word at the largest magnitude. This case, and the matching one at scale −192 where truncation leaves an empty magnitude, come from a sweep of every scale from −200 to 199. The sweep runs against single-bit and adjacent-bit fraction patterns, so each of the five layouts sees exact ties with both even and odd kept LSBs. Results are compared with a bench model that packs the fields serially, one bit at a time. Zero and NaR raised together check the flag priority.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

    localparam int EXP_W     = 5;     // exponent field width, fixed
    localparam int REG_MAX   = 6;     // longest regime run
    localparam int N_LAYOUTS = REG_MAX - 1;  // regime lengths 2..6
    localparam int SCALE_TOP = 192;   // first scale that saturates high
    localparam int SCALE_BOT = -192;  // lowest scale still encoded

    // Layout index (regime length minus two) from the 4-bit regime value.
    function automatic logic [2:0] layout_of(input logic [3:0] rv);
        logic [3:0] run_len;
        run_len = rv[3] ? ~rv : rv;   // ~r == -r-1 for negative r
        return (run_len > 4'd4) ? 3'd4 : run_len[2:0];
    endfunction

endpackage

// File: rtl/bpe_field_pack.sv
module bpe_field_pack
    import bpe_pkg::*;
#(
    parameter int NBITS = 16,
    parameter int FW    = 16,
    localparam int MW   = NBITS - 1
) (
    input  logic [EXP_W-1:0] expo_i,
    input  logic             run_i,      // regime run bit value
    input  logic             term_i,     // regime terminator present
    input  logic [2:0]       sel_i,      // layout index
    input  logic [FW-1:0]    frac_i,
    input  logic             sticky_i,
    output logic [MW-1:0]    mag_o,
    output logic             guard_o,
    output logic             sticky_o
);

    logic [MW-1:0] cand_mag [N_LAYOUTS];
    logic          cand_g   [N_LAYOUTS];
    logic          cand_s   [N_LAYOUTS];

    for (genvar g = 0; g < N_LAYOUTS; g++) begin : g_layout
        localparam int RLEN = g + 2;
        localparam int FBIT = MW - RLEN - EXP_W;
        localparam int DROP = FW - FBIT;
        logic [RLEN-1:0] reg_bits;

        assign reg_bits    = {{(RLEN-1){run_i}}, term_i ? ~run_i : run_i};
        assign cand_mag[g] = {reg_bits, expo_i, frac_i[FW-1 -: FBIT]};
        assign cand_g[g]   = frac_i[DROP-1];
        if (DROP >= 2) begin : g_st
            assign cand_s[g] = (|frac_i[DROP-2:0]) | sticky_i;
        end else begin : g_nost
            assign cand_s[g] = sticky_i;
        end
    end

    always_comb begin
        case (sel_i)
            3'd1:    begin mag_o = cand_mag[1]; guard_o = cand_g[1]; sticky_o = cand_s[1]; end
            3'd2:    begin mag_o = cand_mag[2]; guard_o = cand_g[2]; sticky_o = cand_s[2]; end
            3'd3:    begin mag_o = cand_mag[3]; guard_o = cand_g[3]; sticky_o = cand_s[3]; end
            3'd4:    begin mag_o = cand_mag[4]; guard_o = cand_g[4]; sticky_o = cand_s[4]; end
            default: begin mag_o = cand_mag[0]; guard_o = cand_g[0]; sticky_o = cand_s[0]; end
        endcase
    end

endmodule

// File: rtl/bpe_round.sv
module bpe_round #(
    parameter int MW = 15
) (
    input  logic [MW-1:0] mag_i,
    input  logic          guard_i,
    input  logic          sticky_i,
    output logic [MW-1:0] mag_o
);

    logic          bump;
    logic [MW:0]   sum;

    always_comb begin
        bump = guard_i & (mag_i[0] | sticky_i);
        sum  = {1'b0, mag_i} + {{MW{1'b0}}, bump};
        if (sum[MW]) begin
            mag_o = {MW{1'b1}};                 // never carry into NaR
        end else if (sum[MW-1:0] == '0) begin
            mag_o = {{(MW-1){1'b0}}, 1'b1};     // never collapse to zero
        end else begin
            mag_o = sum[MW-1:0];
        end
    end

endmodule

// File: rtl/bposit_encoder.sv
module bposit_encoder
    import bpe_pkg::*;
#(
    parameter int NBITS = 16,
    parameter int FW    = 16,
    parameter int SCW   = 10,
    localparam int MW   = NBITS - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sign_i,
    input  logic signed [SCW-1:0] scale_i,
    input  logic [FW-1:0]         frac_i,
    input  logic                  sticky_i,
    input  logic                  zero_i,
    input  logic                  nar_i,
    output logic [NBITS-1:0]      word_o
);

    typedef struct packed {
        logic [NBITS-1:0] word;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic [3:0]       regime;
    logic             run_bit;
    logic             term_bit;
    logic [2:0]       layout;
    logic [MW-1:0]    packed_mag;
    logic             guard_bit;
    logic             sticky_bit;
    logic [MW-1:0]    rounded_mag;
    logic             over_hi;
    logic             under_lo;

    assign regime   = scale_i[EXP_W+3:EXP_W];
    assign run_bit  = ~regime[3];
    assign term_bit = !((regime == 4'sd5) || (regime == 4'b1010));
    assign layout   = layout_of(regime);
    assign over_hi  = (scale_i >= SCALE_TOP);
    assign under_lo = (scale_i < SCALE_BOT);

    bpe_field_pack #(.NBITS(NBITS), .FW(FW)) u_pack (
        .expo_i   (scale_i[EXP_W-1:0]),
        .run_i    (run_bit),
        .term_i   (term_bit),
        .sel_i    (layout),
        .frac_i   (frac_i),
        .sticky_i (sticky_i),
        .mag_o    (packed_mag),
        .guard_o  (guard_bit),
        .sticky_o (sticky_bit)
    );

    bpe_round #(.MW(MW)) u_round (
        .mag_i    (packed_mag),
        .guard_i  (guard_bit),
        .sticky_i (sticky_bit),
        .mag_o    (rounded_mag)
    );

    always_comb begin
        logic [MW-1:0] mag_d;
        if (over_hi)       mag_d = {MW{1'b1}};
        else if (under_lo) mag_d = {{(MW-1){1'b0}}, 1'b1};
        else               mag_d = rounded_mag;

        if (nar_i)         st_d.word = {1'b1, {MW{1'b0}}};
        else if (zero_i)   st_d.word = '0;
        else if (sign_i)   st_d.word = -{1'b0, mag_d};
        else               st_d.word = {1'b0, mag_d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
    parameter int NBITS = 16,
    parameter int SCW   = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sign_i,
    input logic signed [SCW-1:0] scale_i,
    input logic                  zero_i,
    input logic                  nar_i,
    input logic [NBITS-1:0]      word_o
);

    localparam logic [NBITS-1:0] NAR_W = {1'b1, {(NBITS-1){1'b0}}};
    localparam logic [NBITS-1:0] MAX_W = {1'b0, {(NBITS-1){1'b1}}};

    assert_nar_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nar_i |=> word_o == NAR_W);

    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_i && !nar_i) |=> word_o == '0);

    assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && !nar_i && !sign_i && scale_i >= 192) |=> word_o == MAX_W);

    assert_no_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && !nar_i) |=> (word_o != '0) && (word_o != NAR_W));

    assert_sign_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && !nar_i) |=> word_o[NBITS-1] == $past(sign_i));

endmodule

bind bposit_encoder bpe_checker #(.NBITS(NBITS), .SCW(SCW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sign_i  (sign_i),
    .scale_i (scale_i),
    .zero_i  (zero_i),
    .nar_i   (nar_i),
    .word_o  (word_o)
);

// File: tb/sim_bposit_encoder.sv
`timescale 1ns/100ps
module sim_bposit_encoder;

    localparam int NB  = 16;
    localparam int FWB = 16;
    localparam int SCB = 10;
    localparam int MB  = NB - 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  sign_i = 1'b0;
    logic signed [SCB-1:0] scale_i = '0;
    logic [FWB-1:0]        frac_i = '0;
    logic                  sticky_i = 1'b0;
    logic                  zero_i = 1'b0;
    logic                  nar_i = 1'b0;
    logic [NB-1:0]         word_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bposit_encoder #(.NBITS(NB), .FW(FWB), .SCW(SCB)) u0 (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .scale_i(scale_i),
        .frac_i(frac_i), .sticky_i(sticky_i), .zero_i(zero_i),
        .nar_i(nar_i), .word_o(word_o)
    );

    task automatic check(input string tag, input logic [NB-1:0] got, input logic [NB-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Serial reference: emit regime, exponent, fraction, sticky bit by bit.
    function automatic logic [NB-1:0] model(input logic sg, input int sc,
                                            input logic [FWB-1:0] fr, input logic st,
                                            input logic zf, input logic nf);
        logic [63:0]   bits;
        int            pos;
        int            e, r, nrun;
        logic [MB-1:0] mag;
        logic          gd, sk;
        if (nf) return {1'b1, {MB{1'b0}}};
        if (zf) return '0;
        if (sc >= 192) mag = {MB{1'b1}};
        else if (sc < -192) mag = 1;
        else begin
            bits = '0;
            pos  = 63;
            e    = sc & 31;
            r    = (sc - e) / 32;
            nrun = (r >= 0) ? r + 1 : -r;
            if (nrun > 6) nrun = 6;
            for (int i = 0; i < nrun; i++) begin bits[pos] = (r >= 0); pos--; end
            if (nrun < 6) begin bits[pos] = (r < 0); pos--; end
            for (int i = 4; i >= 0; i--) begin bits[pos] = e[i]; pos--; end
            for (int i = FWB - 1; i >= 0; i--) begin bits[pos] = fr[i]; pos--; end
            bits[pos] = st;
            mag = bits[63 -: MB];
            gd  = bits[63 - MB];
            sk  = |bits[62 - MB:0];
            if (gd && (mag[0] || sk)) begin
                if (mag != {MB{1'b1}}) mag = mag + 1'b1;
            end
            if (mag == '0) mag = 1;
        end
        return sg ? -{1'b0, mag} : {1'b0, mag};
    endfunction

    task automatic apply(input string tag, input logic sg, input int sc,
                         input logic [FWB-1:0] fr, input logic st,
                         input logic zf, input logic nf);
        @(negedge clk);
        sign_i = sg; scale_i = SCB'(sc); frac_i = fr; sticky_i = st;
        zero_i = zf; nar_i = nf;
        @(posedge clk);
        #1;
        check(tag, word_o, model(sg, sc, fr, st, zf, nf));
    endtask

    task automatic apply_fixed(input string tag, input logic sg, input int sc,
                               input logic [FWB-1:0] fr, input logic st,
                               input logic [NB-1:0] exp);
        @(negedge clk);
        sign_i = sg; scale_i = SCB'(sc); frac_i = fr; sticky_i = st;
        zero_i = 1'b0; nar_i = 1'b0;
        @(posedge clk);
        #1;
        check(tag, word_o, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [FWB-1:0] pat;
        string tag;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", word_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 / R5 / R6 / R8 / R9 directed values (16-bit word)
        apply_fixed("R4 scale0",        1'b0,    0, 16'h0000, 1'b0, 16'h4000);
        apply_fixed("R4 r5_no_term",    1'b0,  160, 16'h0000, 1'b0, 16'h7E00);
        apply_fixed("R4 rm6_no_term",   1'b0, -192, 16'h8000, 1'b0, 16'h0008);
        apply_fixed("R5 exponent",      1'b0,   31, 16'h0000, 1'b0, 16'h5F00);
        apply_fixed("R6 tie_even",      1'b0,    0, 16'h0080, 1'b0, 16'h4000);
        apply_fixed("R6 tie_odd",       1'b0,    0, 16'h0180, 1'b0, 16'h4002);
        apply_fixed("R6 sticky_up",     1'b0,    0, 16'h0080, 1'b1, 16'h4001);
        apply_fixed("R8 carry_clamp",   1'b0,  191, 16'hFFFF, 1'b1, 16'h7FFF);
        apply_fixed("R8 empty_to_min",  1'b0, -192, 16'h0000, 1'b1, 16'h0001);
        apply_fixed("R9 negate",        1'b1,    0, 16'h0000, 1'b0, 16'hC000);
        apply_fixed("R7 high",          1'b0,  300, 16'h1234, 1'b0, 16'h7FFF);
        apply_fixed("R7 low",           1'b0, -300, 16'h1234, 1'b0, 16'h0001);

        // R2 / R3: flags, including both raised in the same cycle
        apply("R2 nar",       1'b1,   50, 16'hABCD, 1'b1, 1'b0, 1'b1);
        apply("R2 nar_zero",  1'b0,  -20, 16'h0001, 1'b0, 1'b1, 1'b1);
        apply("R3 zero",      1'b1,  191, 16'hFFFF, 1'b1, 1'b1, 1'b0);

        // R10: output holds until the next rising edge
        @(negedge clk);
        sign_i = 1'b0; scale_i = SCB'(0); frac_i = '0; sticky_i = 1'b0;
        zero_i = 1'b0; nar_i = 1'b0;
        #1;
        check("R10 hold", word_o, '0);
        @(posedge clk);
        #1;
        check("R10 update", word_o, 16'h4000);

        // Sweep: every scale, both signs, tie-provoking fraction patterns
        for (int sc = -200; sc < 200; sc++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int p = 0; p < 33; p++) begin
                    for (int st = 0; st < 2; st++) begin
                        if (p == 0)      pat = '0;
                        else if (p == 1) pat = '1;
                        else if (p < 18) pat = FWB'(1) << (p - 2);
                        else             pat = FWB'(3) << (p - 18);
                        if (sc >= 192 || sc < -192) tag = "R7 sweep";
                        else if (sg == 1)           tag = "R9 sweep";
                        else                        tag = "R6 sweep";
                        apply(tag, sg[0], sc, pat, st[0], 1'b0, 1'b0);
                    end
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule